// File: doc/BRIEF.md
# Signed binary to BCD converter

This block turns a signed two's complement word into the decimal digits of its magnitude, so that the result of an arithmetic step can be shown on a decimal display. It is purely combinational. The digits follow the input word without any clock, start strobe or wait.

A negative word is first turned into its positive magnitude by inverting every bit and adding one. The magnitude then passes through a fully unrolled shift-and-add-3 network. In each stage, every decimal nibble that holds 5 to 9 is raised by 3, and the whole scratch vector is then shifted one place left.

The block has no sign output. A caller that needs the sign reads the top bit of the word it supplied. With the default 10-bit width, the magnitude runs up to 512, so three digits are enough.

Top module: `sbin_to_bcd`

## Requirements
- R1: `value_in` is a 10-bit two's complement word whose bit 9 is the sign. The magnitude that is converted is the value itself when bit 9 is clear, and its negation when bit 9 is set. The hundreds digit therefore never exceeds 5.
- R2: `bcd_out` carries the ones digit in bits [3:0], the tens digit in bits [7:4] and the hundreds digit in bits [11:8]. Each digit is plain BCD in the range 0 to 9.
- R3: For every input from 1 to 511, the three digits equal the decimal form of the input.
- R4: For every input from -1 to -511, the three digits equal the decimal form of the input's absolute value.
- R5: The most negative input, -512 (10'h200), gives `bcd_out` = 12'h512.
- R6: No sign is reported. An input and its negation produce identical digits.
- R7: The output settles to the new digits within the same clock period in which the input changes, with no clock edge in between.
- R8: An input of zero gives `bcd_out` = 12'h000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| value_in | input | 10 | Two's complement word to convert |
| bcd_out | output | 12 | Magnitude as hundreds, tens and ones BCD digits |

## Verification
The bench sweeps all 1024 input words and adds random words from a fixed seed, with expected digits worked out by division and remainder. It singles out -512. A design whose negation drops the carry, or that treats bit 9 as data, shows 000 or a wrong hundreds digit for that input. Pairs of x and -x catch a design that leaks the sign into the digits or forgets to add one after inverting; such a design is off by one for every negative input. Inputs with digits near 4 and 5, such as 49, 50, 95, 149 and 499, expose an adjust cell whose threshold is off by one: it would produce nibbles above 9 or carry into the wrong digit.

// File: rtl/sbcd_pkg.sv
package sbcd_pkg;

    localparam int NIB_W = 4;

    typedef logic [NIB_W-1:0] bcd_nib_t;

    // Raise a nibble holding 5..9 by three; other values pass unchanged.
    function automatic bcd_nib_t adjust_nib(input bcd_nib_t n);
        if (n >= 4'd5 && n <= 4'd9)
            return n + 4'd3;
        return n;
    endfunction

endpackage

// File: rtl/sbcd_abs.sv
module sbcd_abs #(
    parameter int W = 10
) (
    input  logic [W-1:0] val_i,
    output logic [W-1:0] mag_o
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic is_neg;

    assign is_neg = val_i[W-1];
    assign mag_o  = is_neg ? (~val_i + ONE) : val_i;
endmodule

// File: rtl/sbcd_adj_cell.sv
module sbcd_adj_cell
    import sbcd_pkg::*;
(
    input  bcd_nib_t nib_i,
    output bcd_nib_t nib_o
);
    assign nib_o = adjust_nib(nib_i);
endmodule

// File: rtl/sbcd_dabble_net.sv
module sbcd_dabble_net
    import sbcd_pkg::*;
#(
    parameter int MAG_W  = 10,
    parameter int DIGITS = 3
) (
    input  logic [MAG_W-1:0]        mag_i,
    output logic [DIGITS*NIB_W-1:0] bcd_o
);
    localparam int BCD_W = DIGITS * NIB_W;
    localparam int SCR_W = BCD_W + MAG_W;

    // scr[s] is the scratch vector entering stage s
    logic [MAG_W:0][SCR_W-1:0] scr;

    assign scr[0] = {{BCD_W{1'b0}}, mag_i};

    generate
        for (genvar s = 0; s < MAG_W; s++) begin : g_stage
            logic [SCR_W-1:0] adj;

            assign adj[MAG_W-1:0] = scr[s][MAG_W-1:0];

            for (genvar d = 0; d < DIGITS; d++) begin : g_digit
                sbcd_adj_cell u_cell (
                    .nib_i (scr[s][MAG_W + NIB_W*d +: NIB_W]),
                    .nib_o (adj[MAG_W + NIB_W*d +: NIB_W])
                );
            end

            assign scr[s+1] = {adj[SCR_W-2:0], 1'b0};
        end
    endgenerate

    assign bcd_o = scr[MAG_W][SCR_W-1 -: BCD_W];
endmodule

// File: rtl/sbin_to_bcd.sv
module sbin_to_bcd
    import sbcd_pkg::*;
#(
    parameter int DATA_W = 10,
    parameter int DIGITS = 3
) (
    input  logic [DATA_W-1:0]       value_in,
    output logic [DIGITS*NIB_W-1:0] bcd_out
);
    logic [DATA_W-1:0] magnitude;

    sbcd_abs #(.W(DATA_W)) u_abs (
        .val_i (value_in),
        .mag_o (magnitude)
    );

    sbcd_dabble_net #(.MAG_W(DATA_W), .DIGITS(DIGITS)) u_net (
        .mag_i (magnitude),
        .bcd_o (bcd_out)
    );
endmodule

// File: rtl/sbcd_checker.sv
module sbcd_checker #(
    parameter int DATA_W = 10,
    parameter int DIGITS = 3
) (
    input logic [DATA_W-1:0]   value_in,
    input logic [DIGITS*4-1:0] bcd_out
);
    always_comb begin
        int sv;
        int mag;
        int wsum;
        int weight;
        logic digits_ok;
        sv        = int'($signed(value_in));
        mag       = (sv < 0) ? -sv : sv;
        wsum      = 0;
        weight    = 1;
        digits_ok = 1'b1;
        for (int d = 0; d < DIGITS; d++) begin
            if (bcd_out[4*d +: 4] > 4'd9) digits_ok = 1'b0;
            wsum   = wsum + weight * int'(bcd_out[4*d +: 4]);
            weight = weight * 10;
        end
        a_r2_digit_range: assert (digits_ok)
            else $error("R2 digit above 9: %h", bcd_out);
        a_r4_weighted_value: assert (wsum == mag)
            else $error("R3/R4 digits %h do not encode %0d", bcd_out, mag);
        a_r1_top_digit: assert (bcd_out[4*DIGITS-1 -: 4] <= 4'd5)
            else $error("R1 top digit above 5: %h", bcd_out);
        a_r5_most_negative: assert (!(sv == -(1 << (DATA_W-1))) || wsum == (1 << (DATA_W-1)))
            else $error("R5 most negative input gave %h", bcd_out);
        a_r8_zero: assert (value_in != '0 || bcd_out == '0)
            else $error("R8 zero input gave %h", bcd_out);
    end
endmodule

bind sbin_to_bcd sbcd_checker #(.DATA_W(DATA_W), .DIGITS(DIGITS)) u_chk (
    .value_in (value_in),
    .bcd_out  (bcd_out)
);

// File: tb/test_sbin_to_bcd.sv
module test_sbin_to_bcd;
    logic        clk = 1'b0;
    logic [9:0]  value_in = '0;
    logic [11:0] bcd_out;
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    sbin_to_bcd i_sbin_to_bcd (
        .value_in (value_in),
        .bcd_out  (bcd_out)
    );

    function automatic logic [11:0] exp_bcd(input int v);
        int m;
        m = (v < 0) ? -v : v;
        return {4'((m / 100) % 10), 4'((m / 10) % 10), 4'(m % 10)};
    endfunction

    function automatic int as_int(input logic [9:0] w);
        return int'($signed(w));
    endfunction

    function automatic string req_of(input int v);
        if (v == -512) return "R5";
        if (v == 0)    return "R8";
        if (v < 0)     return "R4";
        return "R3";
    endfunction

    // drive at the falling edge, compare 1 ns later, before the next rising edge (R7)
    task automatic apply_check(input logic [9:0] w);
        @(negedge clk);
        value_in = w;
        #1;
        checks++;
        if (bcd_out !== exp_bcd(as_int(w))) begin
            fails++;
            $display("FAIL %s/R7 in=%0d got=%h exp=%h", req_of(as_int(w)), as_int(w),
                     bcd_out, exp_bcd(as_int(w)));
        end
        checks++;
        if (bcd_out[3:0] > 4'd9 || bcd_out[7:4] > 4'd9 || bcd_out[11:8] > 4'd5) begin
            fails++;
            $display("FAIL R2/R1 in=%0d got=%h exp=digits<=9,top<=5", as_int(w), bcd_out);
        end
    endtask

    // R6: a word and its negation give the same digits
    task automatic pair_check(input int v);
        logic [11:0] a;
        @(negedge clk);
        value_in = 10'(v);
        #1;
        a = bcd_out;
        @(negedge clk);
        value_in = 10'(-v);
        #1;
        checks++;
        if (bcd_out !== a) begin
            fails++;
            $display("FAIL R6 v=%0d got=%h exp=%h", v, bcd_out, a);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired got=running exp=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [9:0] r;
        void'($urandom(32'd20250611));
        // reset-time state: zero input (R8)
        #1;
        checks++;
        if (bcd_out !== 12'h000) begin
            fails++;
            $display("FAIL R8 initial got=%h exp=000", bcd_out);
        end
        // directed corners
        apply_check(10'h200);      // R5: -512
        apply_check(10'h000);      // R8
        apply_check(10'h1FF);      // R3: 511
        apply_check(10'h3FF);      // R4: -1
        apply_check(10'd49);
        apply_check(10'd50);
        apply_check(10'd95);
        apply_check(10'd149);
        apply_check(10'd499);
        apply_check(10'(-100));    // R4
        // full sweep over every word (R1, R3, R4)
        for (int i = 0; i < 1024; i++) apply_check(10'(i));
        // seeded random words
        for (int k = 0; k < 500; k++) begin
            r = 10'($urandom);
            apply_check(r);
        end
        // sign symmetry (R6)
        for (int v = 1; v < 512; v += 7) pair_check(v);
        pair_check(511);
        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule